// File: doc/BRIEF.md
# Sixteen-Bit Multi-Mode Timer/Counter

This peripheral holds one 16-bit count register and one 16-bit capture/reload register. Each is reachable as two bytes through a simple synchronous register port. Five behaviours are available, and the configuration bytes pick one of them:

- free-running count with a trigger-driven snapshot;
- auto-reload;
- auto-reload with direction chosen by a pin;
- overflow-pulse source for a serial port's bit clock;
- square-wave output generator.

The count advances on a per-cycle enable strobe. In counter mode it advances on falling edges of an external input instead.

Two sticky flags record events: an overflow flag (TF) and an external-event flag (EXF). They share one interrupt line. Software clears them by writing the control byte. The trigger pin has several roles. It can snapshot the count, force a reload, set EXF, or choose the counting direction.

Top module: `tmr16_top`

## Requirements
- R1: Register map on `reg_addr`: 0 control, 1 options, 2 count low, 3 count high, 4 capture low, 5 capture high; 6 and 7 read as zero. Control bits: 0 run, 1 counter-mode, 2 capture-select, 3 trigger-enable, 4 rx-clock, 5 tx-clock, 6 EXF, 7 TF. Option bits: 0 down-enable, 1 output-enable, 2 irq-enable. After reset every register, `irq`, `baud_pulse` and `clk_out` are zero.
- R2: Mode priority: rx-clock or tx-clock selects the baud mode. Otherwise output-enable selects clock-out. Otherwise capture-select selects capture. Otherwise down-enable selects up/down. Otherwise the mode is auto-reload.
- R3: The count advances only while run is 1. With counter-mode 0 it advances once per cycle with `tick` high. With counter-mode 1 it advances once per sampled falling edge of `cnt_pin`, and `tick` is ignored.
- R4: Capture mode: the count increments and wraps from 0xFFFF to 0x0000, which sets TF; no reload happens.
- R5: Capture mode: a sampled falling edge of `trig_pin` while trigger-enable is 1 copies the count into the capture register and sets EXF. With trigger-enable 0 the edge changes nothing.
- R6: Auto-reload mode: a step from 0xFFFF loads the capture value and sets TF. A qualified trigger edge also loads the capture value and sets EXF.
- R7: Up/down mode: the sampled `trig_pin` level chooses the direction (1 up, 0 down).
  - Counting up, a step from 0xFFFF loads the capture value.
  - Counting down, a step from a count less than or equal to the capture value loads 0xFFFF; any other step decrements.
  - Each reload sets TF and toggles EXF. Trigger edges never set EXF in this mode.
- R8: Baud mode: a step from 0xFFFF loads the capture value and raises `baud_pulse` for exactly the next cycle. TF is untouched. A qualified trigger edge sets EXF and leaves the count unchanged.
- R9: Clock-out mode: a step from 0xFFFF loads the capture value and inverts `clk_out`; TF is untouched.
- R10: `irq` is irq-enable AND (TF OR EXF). EXF is excluded in up/down mode.
- R11: When a hardware flag event and a software control write fall in the same cycle, the flag ends up set.
- R12: A control or option write that changes the decoded mode discards any trigger or count edge detected in that cycle.
- R13: A software write to a count or capture byte overrides any hardware update of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Per-cycle count enable (timer mode) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | External trigger / direction input |
| irq | output | 1 | Interrupt request |
| baud_pulse | output | 1 | One-cycle overflow pulse in baud mode |
| clk_out | output | 1 | Toggling clock output |

## Verification
The hardest situation to reach is a trigger edge that is already detected in the same cycle as a configuration write that changes the mode. R12 says that edge must be dropped rather than applied in either the old or the new mode. The bench drops the trigger pin and then issues the control write at the next falling clock edge. This places the write exactly on the cycle in which the sampled edge would act. The bench then checks that the count, the capture register and EXF are all untouched, and shows that a later edge is honoured normally. The same-cycle collisions of R11 and R13 are set up the same way, with the strobe and the write driven in one cycle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int CTRL_W = 8;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_OPT  = 3'd1;
    localparam logic [2:0] A_CNTL = 3'd2;
    localparam logic [2:0] A_CNTH = 3'd3;
    localparam logic [2:0] A_CAPL = 3'd4;
    localparam logic [2:0] A_CAPH = 3'd5;

    typedef enum logic [2:0] {
        M_RELOAD  = 3'd0,
        M_CAPTURE = 3'd1,
        M_UPDOWN  = 3'd2,
        M_BAUD    = 3'd3,
        M_CLKOUT  = 3'd4
    } mode_e;

    typedef struct packed {
        logic tf;
        logic exf;
        logic tx_clk;
        logic rx_clk;
        logic ext_en;
        logic cap_sel;
        logic cnt_sel;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       irq_en;
        logic       out_en;
        logic       down_en;
    } opt_t;

endpackage

// File: rtl/tmr16_mode_dec.sv
module tmr16_mode_dec
    import tmr16_pkg::*;
(
    input  ctrl_t ctrl,
    input  opt_t  opt,
    output mode_e mode
);
    always_comb begin
        if (ctrl.rx_clk || ctrl.tx_clk) begin
            mode = M_BAUD;
        end else if (opt.out_en) begin
            mode = M_CLKOUT;
        end else if (ctrl.cap_sel) begin
            mode = M_CAPTURE;
        end else if (opt.down_en) begin
            mode = M_UPDOWN;
        end else begin
            mode = M_RELOAD;
        end
    end
endmodule

// File: rtl/tmr16_edge.sv
module tmr16_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic lvl,
    output logic fall
);
    logic smp_q, smp_d;
    logic prv_q, prv_d;

    always_comb begin
        smp_d = pin;
        prv_d = clr ? 1'b0 : smp_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
            prv_q <= 1'b0;
        end else begin
            smp_q <= smp_d;
            prv_q <= prv_d;
        end
    end

    assign lvl  = smp_q;
    assign fall = prv_q & ~smp_q & ~clr;
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
    import tmr16_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          cnt_pin,
    input  logic          trig_pin,
    output logic          irq,
    output logic          baud_pulse,
    output logic          clk_out
);
    localparam int CW     = 2 * DW;
    localparam int NPIN   = 2;
    localparam int P_TRIG = 0;
    localparam int P_CNT  = 1;

    typedef struct packed {
        ctrl_t         ctrl;
        opt_t          opt;
        logic [CW-1:0] cnt;
        logic [CW-1:0] cap;
        logic          clk_o;
        logic          baud;
    } st_t;

    st_t   st_q, st_d;
    ctrl_t ctrl_w;
    opt_t  opt_w;
    mode_e mode_cur, mode_nx;
    logic  mode_chg;

    logic [NPIN-1:0] pin_v, lvl_v, fall_v;

    // configuration bytes as they will be after this cycle's write
    always_comb begin
        ctrl_w = st_q.ctrl;
        opt_w  = st_q.opt;
        if (reg_wr && reg_addr == A_CTRL) ctrl_w = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        if (reg_wr && reg_addr == A_OPT)  opt_w  = opt_t'(reg_wdata[CTRL_W-1:0]);
    end

    tmr16_mode_dec u_dec_cur (.ctrl(st_q.ctrl), .opt(st_q.opt), .mode(mode_cur));
    tmr16_mode_dec u_dec_nx  (.ctrl(ctrl_w),    .opt(opt_w),    .mode(mode_nx));

    assign mode_chg = (mode_nx != mode_cur);

    assign pin_v[P_TRIG] = trig_pin;
    assign pin_v[P_CNT]  = cnt_pin;

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
        tmr16_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_v[gi]),
            .clr  (mode_chg),
            .lvl  (lvl_v[gi]),
            .fall (fall_v[gi])
        );
    end

    logic step, trg, at_top;

    always_comb begin
        st_d      = st_q;
        st_d.ctrl = ctrl_w;
        st_d.opt  = opt_w;
        st_d.baud = 1'b0;

        step   = st_q.ctrl.run & (st_q.ctrl.cnt_sel ? fall_v[P_CNT] : tick);
        trg    = st_q.ctrl.ext_en & fall_v[P_TRIG];
        at_top = (st_q.cnt == {CW{1'b1}});

        unique case (mode_cur)
            M_CAPTURE: begin
                if (trg) begin
                    st_d.cap      = st_q.cnt;
                    st_d.ctrl.exf = 1'b1;
                end
                if (step) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (at_top) st_d.ctrl.tf = 1'b1;
                end
            end
            M_RELOAD: begin
                if (trg) begin
                    st_d.cnt      = st_q.cap;
                    st_d.ctrl.exf = 1'b1;
                end else if (step) begin
                    if (at_top) begin
                        st_d.cnt     = st_q.cap;
                        st_d.ctrl.tf = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            M_UPDOWN: begin
                if (step) begin
                    if (lvl_v[P_TRIG]) begin
                        if (at_top) begin
                            st_d.cnt      = st_q.cap;
                            st_d.ctrl.tf  = 1'b1;
                            st_d.ctrl.exf = ~st_d.ctrl.exf;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end else begin
                        if (st_q.cnt <= st_q.cap) begin
                            st_d.cnt      = {CW{1'b1}};
                            st_d.ctrl.tf  = 1'b1;
                            st_d.ctrl.exf = ~st_d.ctrl.exf;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
            end
            M_BAUD: begin
                if (trg) st_d.ctrl.exf = 1'b1;
                if (step) begin
                    if (at_top) begin
                        st_d.cnt  = st_q.cap;
                        st_d.baud = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            M_CLKOUT: begin
                if (trg) st_d.ctrl.exf = 1'b1;
                if (step) begin
                    if (at_top) begin
                        st_d.cnt   = st_q.cap;
                        st_d.clk_o = ~st_q.clk_o;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: ;
        endcase

        // software writes to data registers take precedence
        if (reg_wr) begin
            unique case (reg_addr)
                A_CNTL:  st_d.cnt[DW-1:0]  = reg_wdata;
                A_CNTH:  st_d.cnt[CW-1:DW] = reg_wdata;
                A_CAPL:  st_d.cap[DW-1:0]  = reg_wdata;
                A_CAPH:  st_d.cap[CW-1:DW] = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = DW'(st_q.ctrl);
            A_OPT:   reg_rdata = DW'(st_q.opt);
            A_CNTL:  reg_rdata = st_q.cnt[DW-1:0];
            A_CNTH:  reg_rdata = st_q.cnt[CW-1:DW];
            A_CAPL:  reg_rdata = st_q.cap[DW-1:0];
            A_CAPH:  reg_rdata = st_q.cap[CW-1:DW];
            default: reg_rdata = '0;
        endcase
    end

    assign irq        = st_q.opt.irq_en &
                        (st_q.ctrl.tf | (st_q.ctrl.exf & (mode_cur != M_UPDOWN)));
    assign baud_pulse = st_q.baud;
    assign clk_out    = st_q.clk_o;

    // observation points for the bound checker
    logic [CW-1:0] cnt_now;
    logic          tf_now;
    logic          run_now;
    assign cnt_now = st_q.cnt;
    assign tf_now  = st_q.ctrl.tf;
    assign run_now = st_q.ctrl.run;

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
    import tmr16_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          run,
    input logic          tf,
    input logic          baud_pulse,
    input logic          clk_out,
    input mode_e         mode_cur,
    input logic [CW-1:0] cnt
);
    // R8
    baud_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_pulse |=> !baud_pulse);

    // R8
    baud_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_pulse |-> $past(mode_cur) == M_BAUD);

    // R8
    baud_no_tf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == M_BAUD && !reg_wr && !tf) |=> !tf);

    // R9
    clk_out_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_out) |-> $past(mode_cur) == M_CLKOUT);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_wr && mode_cur != M_RELOAD) |=> $stable(cnt));

    // R3
    tf_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_wr && !tf) |=> !tf);
endmodule

bind tmr16_top tmr16_chk #(.CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .run       (run_now),
    .tf        (tf_now),
    .baud_pulse(baud_pulse),
    .clk_out   (clk_out),
    .mode_cur  (mode_cur),
    .cnt       (cnt_now)
);

// File: tb/tmr16_top_tb_top.sv
module tmr16_top_tb_top;
    import tmr16_pkg::*;

    localparam logic [7:0] C_RUN = 8'h01, C_CNT = 8'h02, C_CAP = 8'h04, C_EXT = 8'h08;
    localparam logic [7:0] C_RX  = 8'h10, C_TX  = 8'h20, C_EXF = 8'h40, C_TF  = 8'h80;
    localparam logic [7:0] O_DOWN = 8'h01, O_OUT = 8'h02, O_IRQ = 8'h04;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       irq, baud_pulse, clk_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tmr16_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .irq(irq), .baud_pulse(baud_pulse), .clk_out(clk_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd16(input logic [2:0] a_lo, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a_lo, lo);
        rd(a_lo + 3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic trig_fall;
        trig_pin = 1'b0;
        repeat (3) @(negedge clk);
        trig_pin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic setup(input logic [15:0] cap, input logic [15:0] cnt);
        wr(A_CTRL, 8'h00);
        wr(A_OPT, 8'h00);
        wr(A_CNTL, cnt[7:0]); wr(A_CNTH, cnt[15:8]);
        wr(A_CAPL, cap[7:0]); wr(A_CAPH, cap[15:8]);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reset register", {8'h0, d}, 16'h0);
        end
        chk("R1 reset irq", {15'h0, irq}, 16'h0);
        chk("R1 reset baud_pulse", {15'h0, baud_pulse}, 16'h0);
        chk("R1 reset clk_out", {15'h0, clk_out}, 16'h0);
    endtask

    task automatic t_capture;
        logic [15:0] v; logic [7:0] d;
        setup(16'h0000, 16'hFFFE);
        wr(A_OPT, O_IRQ);
        wr(A_CTRL, C_RUN | C_CAP);
        ticks(3);
        rd16(A_CNTL, v); chk("R4 wrap without reload", v, 16'h0001);
        rd(A_CTRL, d);   chk("R4 TF on wrap", {8'h0, d}, {8'h0, C_RUN | C_CAP | C_TF});
        chk("R10 irq from TF", {15'h0, irq}, 16'h1);
        wr(A_CTRL, C_CAP | C_EXT);
        trig_fall;
        rd16(A_CAPL, v); chk("R5 snapshot of count", v, 16'h0001);
        rd(A_CTRL, d);   chk("R5 EXF set", {8'h0, d}, {8'h0, C_CAP | C_EXT | C_EXF});
        chk("R10 irq from EXF", {15'h0, irq}, 16'h1);
        wr(A_OPT, 8'h00);
        chk("R10 irq gated by enable", {15'h0, irq}, 16'h0);
        wr(A_CTRL, C_CAP);
        wr(A_CNTL, 8'h22);
        trig_fall;
        rd16(A_CAPL, v); chk("R5 unqualified edge ignored (capture)", v, 16'h0001);
        rd(A_CTRL, d);   chk("R5 unqualified edge ignored (flags)", {8'h0, d}, {8'h0, C_CAP});
    endtask

    task automatic t_reload;
        logic [15:0] v; logic [7:0] d;
        setup(16'hFFF0, 16'hFFFE);
        wr(A_CTRL, C_RUN);
        ticks(3);
        rd16(A_CNTL, v); chk("R6 overflow reload", v, 16'hFFF1);
        rd(A_CTRL, d);   chk("R6 TF on overflow", {8'h0, d}, {8'h0, C_RUN | C_TF});
        wr(A_CTRL, C_EXT);
        wr(A_CNTL, 8'h34); wr(A_CNTH, 8'h12);
        trig_fall;
        rd16(A_CNTL, v); chk("R6 trigger reload", v, 16'hFFF0);
        rd(A_CTRL, d);   chk("R6 EXF on trigger", {8'h0, d}, {8'h0, C_EXT | C_EXF});
        wr(A_CTRL, 8'h00);
        ticks(5);
        rd16(A_CNTL, v); chk("R3 no count while stopped", v, 16'hFFF0);
    endtask

    task automatic t_counter;
        logic [15:0] v;
        setup(16'h0000, 16'h0000);
        wr(A_CTRL, C_RUN | C_CNT);
        tick = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cnt_pin = 1'b0; repeat (3) @(negedge clk);
            cnt_pin = 1'b1; repeat (3) @(negedge clk);
        end
        tick = 1'b0;
        rd16(A_CNTL, v); chk("R3 counts pin edges, tick ignored", v, 16'h0003);
    endtask

    task automatic t_updown;
        logic [15:0] v; logic [7:0] d;
        setup(16'h0010, 16'h0012);
        wr(A_OPT, O_DOWN);
        wr(A_CTRL, C_RUN | C_EXT);
        trig_pin = 1'b0; repeat (3) @(negedge clk);
        rd(A_CTRL, d);   chk("R7 trigger edge sets no EXF", {8'h0, d}, {8'h0, C_RUN | C_EXT});
        ticks(3);
        rd16(A_CNTL, v); chk("R7 down underflow to all-ones", v, 16'hFFFF);
        rd(A_CTRL, d);   chk("R7 TF set, EXF toggled", {8'h0, d}, {8'h0, C_RUN | C_EXT | C_TF | C_EXF});
        wr(A_OPT, O_DOWN | O_IRQ);
        wr(A_CTRL, C_RUN | C_EXT | C_EXF);
        chk("R10 EXF excluded in up/down", {15'h0, irq}, 16'h0);
        trig_pin = 1'b1; repeat (3) @(negedge clk);
        wr(A_CNTL, 8'hFE); wr(A_CNTH, 8'hFF);
        ticks(2);
        rd16(A_CNTL, v); chk("R7 up overflow reload", v, 16'h0010);
        rd(A_CTRL, d);   chk("R7 EXF toggled back", {8'h0, d}, {8'h0, C_RUN | C_EXT | C_TF});
        chk("R10 irq from TF in up/down", {15'h0, irq}, 16'h1);
    endtask

    task automatic t_baud;
        logic [15:0] v; logic [7:0] d;
        setup(16'hFFFD, 16'hFFFE);
        wr(A_CTRL, C_RUN | C_RX | C_EXT);
        ticks(1);
        chk("R8 no pulse before overflow", {15'h0, baud_pulse}, 16'h0);
        ticks(1);
        chk("R8 pulse after overflow", {15'h0, baud_pulse}, 16'h1);
        @(negedge clk);
        chk("R8 pulse lasts one cycle", {15'h0, baud_pulse}, 16'h0);
        rd16(A_CNTL, v); chk("R8 reload from capture", v, 16'hFFFD);
        rd(A_CTRL, d);   chk("R8 TF untouched", {8'h0, d}, {8'h0, C_RUN | C_RX | C_EXT});
        trig_fall;
        rd(A_CTRL, d);   chk("R8 EXF on trigger", {8'h0, d}, {8'h0, C_RUN | C_RX | C_EXT | C_EXF});
        rd16(A_CNTL, v); chk("R8 trigger leaves count", v, 16'hFFFD);
        wr(A_CTRL, C_CAP | C_TX);
        wr(A_CNTL, 8'hFF); wr(A_CNTH, 8'hFF);
        wr(A_CTRL, C_RUN | C_CAP | C_TX);
        ticks(1);
        chk("R2 tx-clock selects baud over capture", {15'h0, baud_pulse}, 16'h1);
        rd16(A_CNTL, v); chk("R2 baud reload", v, 16'hFFFD);
    endtask

    task automatic t_clkout;
        logic [15:0] v; logic [7:0] d;
        setup(16'hFFFE, 16'hFFFE);
        wr(A_OPT, O_OUT);
        wr(A_CTRL, C_RUN);
        ticks(2);
        chk("R9 toggle on overflow", {15'h0, clk_out}, 16'h1);
        rd16(A_CNTL, v); chk("R9 reload", v, 16'hFFFE);
        ticks(2);
        chk("R9 toggle back", {15'h0, clk_out}, 16'h0);
        rd(A_CTRL, d);   chk("R9 TF untouched", {8'h0, d}, {8'h0, C_RUN});
        wr(A_CTRL, C_RUN | C_CAP);
        ticks(2);
        chk("R2 output-enable beats capture", {15'h0, clk_out}, 16'h1);
        rd16(A_CNTL, v); chk("R2 no capture wrap", v, 16'hFFFE);
    endtask

    task automatic t_modechg;
        logic [15:0] v; logic [7:0] d;
        setup(16'h5555, 16'h1234);
        wr(A_CTRL, C_EXT);
        trig_pin = 1'b0;
        @(negedge clk);
        wr(A_CTRL, C_CAP | C_EXT);
        trig_pin = 1'b1; repeat (3) @(negedge clk);
        rd16(A_CNTL, v); chk("R12 edge dropped (count)", v, 16'h1234);
        rd16(A_CAPL, v); chk("R12 edge dropped (capture)", v, 16'h5555);
        rd(A_CTRL, d);   chk("R12 edge dropped (flags)", {8'h0, d}, {8'h0, C_CAP | C_EXT});
        trig_fall;
        rd16(A_CAPL, v); chk("R12 later edge honoured", v, 16'h1234);
    endtask

    task automatic t_collide;
        logic [15:0] v; logic [7:0] d;
        setup(16'h0000, 16'h0000);
        wr(A_CTRL, C_RUN);
        tick = 1'b1; reg_wr = 1'b1; reg_addr = A_CNTL; reg_wdata = 8'h40;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        rd16(A_CNTL, v); chk("R13 write beats count", v, 16'h0040);
        wr(A_CTRL, C_CAP);
        wr(A_CNTL, 8'hFF); wr(A_CNTH, 8'hFF);
        wr(A_CTRL, C_RUN | C_CAP);
        tick = 1'b1; reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = C_RUN | C_CAP;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        rd(A_CTRL, d);   chk("R11 hardware TF wins", {8'h0, d}, {8'h0, C_RUN | C_CAP | C_TF});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_capture;
        t_reload;
        t_counter;
        t_updown;
        t_baud;
        t_clkout;
        t_modechg;
        t_collide;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule